// File: doc/BRIEF.md
# Dual Configurable Decade Counter

The block holds two independent decade counters. Each counter has a divide-by-two stage, which gives output `qA`, and a divide-by-five stage, which gives `qB`, `qC` and `qD`. A per-counter mode input links the stages in one of two ways.

- **BCD mode:** the divide-by-two stage takes the external count input. Each fall of `qA` then advances the divide-by-five stage, so the outputs form a plain binary-coded decimal digit.
- **Bi-quinary mode:** the divide-by-five stage takes the external count input. Each fall of `qD` then toggles `qA`, so `qA` becomes a square wave with 50% duty cycle at one tenth of the input event rate.

Everything runs on one system clock. Each count input is brought in through a two-flop synchroniser and a falling-edge detector, which turns an input fall into a one-cycle enable. The carry between the stages is also a one-cycle enable, taken from the fall of the driving output. Each counter has an asynchronous, active-high clear. Its release is synchronised, and counting resumes only after the release has passed through two flops. Two counters in BCD mode can be chained by feeding the `qD` of the first into the divide-by-two input of the second, which divides the input by 100.

Top module: `dual_decade_counter`

## Requirements
- R1: The divide-by-two stage inverts `qA` once for each accepted count event and holds `qA` otherwise.
- R2: The divide-by-five stage steps {qD,qC,qB} through 000, 001, 010, 011, 100 and then back to 000, with `qB` as the least significant bit; no other value is reachable.
- R3: Only a high-to-low transition of a count input is a count event; a rising transition or a steady level changes nothing.
- R4: While a counter's clear input is high, all four of its outputs are low without waiting for a clock edge, and input transitions are not counted.
- R5: With mode bit 0 (BCD), falls on `tickTwo` step the nibble {qD,qC,qB,qA} through 0 to 9 and back to 0, and transitions on `tickFive` are ignored.
- R6: With mode bit 1 (bi-quinary), after n falls on `tickFive` the outputs hold {qD,qC,qB} = n mod 5 and qA = (n div 5) mod 2, so qA is high for five counts out of every ten; transitions on `tickTwo` are ignored.
- R7: The two counters share only the clock; the clear, mode or count inputs of one never change the outputs of the other.
- R8: With both counters in BCD mode and counter 0's `qD` feeding counter 1's `tickTwo`, after n falls on counter 0's input the pair reads (n div 10) mod 10 on counter 1 and n mod 10 on counter 0, wrapping to 00 after 100 events.
- R9: A count input that is already low when clear is released is not counted. The first event after release is a fall that follows the input being seen high after release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all state updates on its rising edge |
| unitClr | input | NUM_UNITS | Per-counter asynchronous clear, active high |
| biQuinary | input | NUM_UNITS | Per-counter link mode: 0 = BCD, 1 = bi-quinary; change only while cleared |
| tickTwo | input | NUM_UNITS | Per-counter count input of the divide-by-two stage (falling edge counts) |
| tickFive | input | NUM_UNITS | Per-counter count input of the divide-by-five stage (falling edge counts) |
| countQ | output | 4*NUM_UNITS | Per counter u, bits [4u+3:4u] = {qD,qC,qB,qA} |

## Verification
Clear release and an input transition can land in the same few cycles. The bench provokes this by holding a count input low across release and then raising and dropping it. The expected result is no count for the held level and exactly one count for the later fall. A clear can also be asserted mid-sequence while the other counter keeps its value. The bench samples the outputs before any clock edge to confirm that the clear acts at once. In the cascade, the carry out of one counter and a count event on the other arrive through the other counter's synchroniser. The bench checks that the hundreds-style pair matches the arithmetic value after every one of 100 events.

// File: rtl/decade_pkg.sv
package decade_pkg;

  // Strobes sent from the control to the datapath each cycle.
  typedef struct packed {
    logic advTwo;   // toggle the divide-by-two stage
    logic advFive;  // step the divide-by-five stage
  } stageStrobe_t;

  localparam int unsigned FIVE_MOD = 5;
  localparam int unsigned FIVE_W   = $clog2(FIVE_MOD);
  localparam int unsigned NIB_W    = FIVE_W + 1;

endpackage

// File: rtl/decade_edge.sv
// Brings one asynchronous count input into the clock domain and flags its
// high-to-low transitions with a single-cycle pulse.
module decade_edge #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic clr,
  input  logic din,
  output logic fall
);

  localparam int unsigned TOP = SYNC_STAGES - 1;

  logic [TOP:0] syncQ;
  logic         prevQ;

  generate
    if (SYNC_STAGES == 1) begin : gSingle
      always_ff @(posedge clk or posedge clr) begin
        if (clr) syncQ <= '0;
        else     syncQ <= din;
      end
    end else begin : gChain
      always_ff @(posedge clk or posedge clr) begin
        if (clr) syncQ <= '0;
        else     syncQ <= {syncQ[TOP-1:0], din};
      end
    end
  endgenerate

  always_ff @(posedge clk or posedge clr) begin
    if (clr) prevQ <= 1'b0;
    else     prevQ <= syncQ[TOP];
  end

  assign fall = prevQ & ~syncQ[TOP];

endmodule

// File: rtl/decade_ctrl.sv
// Control for one counter: release synchroniser, input edge detection,
// carry detection between stages, and mode steering.
module decade_ctrl
  import decade_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         clr,
  input  logic         biQuinary,
  input  logic         tickTwo,
  input  logic         tickFive,
  input  logic         qA,
  input  logic         qD,
  output stageStrobe_t strobe
);

  logic [1:0] relSync;
  logic       rstDone;
  logic       fallTwo;
  logic       fallFive;
  logic       qAPrev;
  logic       qDPrev;
  logic       carryA;
  logic       carryD;

  always_ff @(posedge clk or posedge clr) begin
    if (clr) relSync <= '0;
    else     relSync <= {relSync[0], 1'b1};
  end
  assign rstDone = relSync[1];

  decade_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edgeTwo (
    .clk(clk), .clr(clr), .din(tickTwo), .fall(fallTwo)
  );

  decade_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edgeFive (
    .clk(clk), .clr(clr), .din(tickFive), .fall(fallFive)
  );

  always_ff @(posedge clk or posedge clr) begin
    if (clr) begin
      qAPrev <= 1'b0;
      qDPrev <= 1'b0;
    end else begin
      qAPrev <= qA;
      qDPrev <= qD;
    end
  end

  assign carryA = qAPrev & ~qA;
  assign carryD = qDPrev & ~qD;

  always_comb begin
    strobe = '0;
    if (rstDone) begin
      strobe.advTwo  = biQuinary ? carryD   : fallTwo;
      strobe.advFive = biQuinary ? fallFive : carryA;
    end
  end

  // R9
  quietRelease_chk: assert property (@(posedge clk) disable iff (clr)
    $rose(rstDone) |-> (!strobe.advTwo && !strobe.advFive));

  // R5
  bcdCarry_chk: assert property (@(posedge clk) disable iff (clr)
    (!biQuinary && strobe.advFive) |-> ($past(qA) && !qA));

endmodule

// File: rtl/decade_dp.sv
// Datapath for one counter: the divide-by-two and divide-by-five stages.
module decade_dp
  import decade_pkg::*;
(
  input  logic         clk,
  input  logic         clr,
  input  stageStrobe_t strobe,
  output logic         qA,
  output logic         qB,
  output logic         qC,
  output logic         qD
);

  localparam logic [FIVE_W-1:0] FIVE_LAST = FIVE_W'(FIVE_MOD - 1);

  logic [FIVE_W-1:0] fiveCnt;

  always_ff @(posedge clk or posedge clr) begin
    if (clr)                qA <= 1'b0;
    else if (strobe.advTwo) qA <= ~qA;
  end

  always_ff @(posedge clk or posedge clr) begin
    if (clr) fiveCnt <= '0;
    else if (strobe.advFive) begin
      if (fiveCnt == FIVE_LAST) fiveCnt <= '0;
      else                      fiveCnt <= fiveCnt + 1'b1;
    end
  end

  assign qB = fiveCnt[0];
  assign qC = fiveCnt[1];
  assign qD = fiveCnt[2];

  // R2
  fiveRange_chk: assert property (@(posedge clk) disable iff (clr)
    fiveCnt <= FIVE_LAST);

  // R2
  fiveWrap_chk: assert property (@(posedge clk) disable iff (clr)
    (strobe.advFive && fiveCnt == FIVE_LAST) |=> (fiveCnt == '0));

  // R1
  qaHold_chk: assert property (@(posedge clk) disable iff (clr)
    !strobe.advTwo |=> $stable(qA));

endmodule

// File: rtl/dual_decade_counter.sv
module dual_decade_counter
  import decade_pkg::*;
#(
  parameter int unsigned NUM_UNITS   = 2,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                       clk,
  input  logic [NUM_UNITS-1:0]       unitClr,
  input  logic [NUM_UNITS-1:0]       biQuinary,
  input  logic [NUM_UNITS-1:0]       tickTwo,
  input  logic [NUM_UNITS-1:0]       tickFive,
  output logic [NUM_UNITS*NIB_W-1:0] countQ
);

  generate
    for (genvar u = 0; u < NUM_UNITS; u++) begin : gUnit
      stageStrobe_t strobe;
      logic qA, qB, qC, qD;

      decade_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
        .clk(clk), .clr(unitClr[u]), .biQuinary(biQuinary[u]),
        .tickTwo(tickTwo[u]), .tickFive(tickFive[u]),
        .qA(qA), .qD(qD), .strobe(strobe)
      );

      decade_dp u_dp (
        .clk(clk), .clr(unitClr[u]), .strobe(strobe),
        .qA(qA), .qB(qB), .qC(qC), .qD(qD)
      );

      assign countQ[u*NIB_W +: NIB_W] = {qD, qC, qB, qA};
    end
  endgenerate

endmodule

// File: tb/dual_decade_counter_bench.sv
module dual_decade_counter_bench;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic [1:0] unitClr;
  logic [1:0] biQuinary;
  logic [1:0] tickTwoDrv;
  logic [1:0] tickTwo;
  logic [1:0] tickFive;
  logic       cascade;
  logic [7:0] countQ;

  int checks   = 0;
  int failures = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign tickTwo[0] = tickTwoDrv[0];
  assign tickTwo[1] = cascade ? countQ[3] : tickTwoDrv[1];

  dual_decade_counter u_dual_decade_counter (
    .clk(clk), .unitClr(unitClr), .biQuinary(biQuinary),
    .tickTwo(tickTwo), .tickFive(tickFive), .countQ(countQ)
  );

  function automatic logic [3:0] nib(input int u);
    return countQ[u*4 +: 4];
  endfunction

  function automatic logic [3:0] bcdExp(input int n);
    return 4'(n % 10);
  endfunction

  function automatic logic [3:0] biqExp(input int n);
    int lo = n % 5;
    int hi = (n / 5) % 2;
    return {3'(lo), 1'(hi)};
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // One event on a count input: high for a while, then low and settle.
  task automatic pulseTwo(input int u);
    tickTwoDrv[u] = 1'b1; waitCyc(4);
    tickTwoDrv[u] = 1'b0; waitCyc(14);
  endtask

  task automatic pulseFive(input int u);
    tickFive[u] = 1'b1; waitCyc(4);
    tickFive[u] = 1'b0; waitCyc(14);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [3:0] held;
    unitClr = 2'b11; biQuinary = 2'b00; tickTwoDrv = 2'b00;
    tickFive = 2'b00; cascade = 1'b0;
    waitCyc(3);
    chk("R4 reset state", countQ, 8'h00);
    unitClr = 2'b00;
    waitCyc(4);

    // R5 / R1 / R2 / R7: BCD sweep on counter 0
    for (int n = 1; n <= 25; n++) begin
      pulseTwo(0);
      chk("R5 bcd count", {4'h0, nib(0)}, {4'h0, bcdExp(n)});
      chk("R7 other counter idle", {4'h0, nib(1)}, 8'h00);
    end

    // R5: tickFive ignored in BCD mode
    held = nib(0);
    pulseFive(0);
    chk("R5 tickFive ignored", {4'h0, nib(0)}, {4'h0, held});

    // R3: rising edge and level do nothing; only the fall counts
    tickTwoDrv[0] = 1'b1; waitCyc(12);
    chk("R3 rising no effect", {4'h0, nib(0)}, {4'h0, held});
    tickTwoDrv[0] = 1'b0; waitCyc(14);
    chk("R3 falling counts", {4'h0, nib(0)}, {4'h0, bcdExp(26)});

    // R7: give counter 1 a value, then clear counter 0 mid-sequence
    pulseTwo(1); pulseTwo(1); pulseTwo(1);
    chk("R7 counter1 counts", {4'h0, nib(1)}, 8'h03);
    @(posedge clk); #2;
    unitClr[0] = 1'b1; #1;
    chk("R4 clear acts at once", {4'h0, nib(0)}, 8'h00);
    pulseTwo(0);
    chk("R4 no count while clear", {4'h0, nib(0)}, 8'h00);
    chk("R7 counter1 kept", {4'h0, nib(1)}, 8'h03);

    // R9: input low across release is not counted
    tickTwoDrv[0] = 1'b0;
    waitCyc(1); unitClr[0] = 1'b0; waitCyc(10);
    chk("R9 low at release", {4'h0, nib(0)}, 8'h00);
    pulseTwo(0);
    chk("R9 first event after release", {4'h0, nib(0)}, 8'h01);

    // R9: input high across release, falls right after release
    unitClr[0] = 1'b1; tickTwoDrv[0] = 1'b1; waitCyc(2);
    unitClr[0] = 1'b0; waitCyc(1);
    tickTwoDrv[0] = 1'b0; waitCyc(14);
    chk("R9 fall soon after release", {4'h0, nib(0)}, 8'h01);

    // R6: bi-quinary sweep on counter 1
    unitClr[1] = 1'b1; biQuinary[1] = 1'b1; waitCyc(2);
    unitClr[1] = 1'b0; waitCyc(4);
    for (int n = 1; n <= 25; n++) begin
      pulseFive(1);
      chk("R6 biquinary count", {4'h0, nib(1)}, {4'h0, biqExp(n)});
    end
    held = nib(1);
    pulseTwo(1);
    chk("R6 tickTwo ignored", {4'h0, nib(1)}, {4'h0, held});
    chk("R7 counter0 kept", {4'h0, nib(0)}, 8'h01);

    // R8: chained divide by 100
    unitClr = 2'b11; biQuinary = 2'b00; tickTwoDrv = 2'b00;
    tickFive = 2'b00; cascade = 1'b1; waitCyc(2);
    unitClr = 2'b00; waitCyc(4);
    for (int n = 1; n <= 100; n++) begin
      pulseTwo(0);
      chk("R8 cascade", countQ, {bcdExp((n / 10) % 10), bcdExp(n)});
    end
    chk("R8 wrap to zero", countQ, 8'h00);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule